// File: doc/BRIEF.md
# Host command port decoder

This block is the device end of a two-port host interface. The host puts command bytes on a command port at I/O address 0x66. It passes parameter bytes and collects result bytes through a data port at I/O address 0x62. Three opcodes are decoded:

- **0x90, read:** takes one address byte and returns one byte.
- **0x91, write:** takes an address byte and then a data byte, and returns nothing.
- **0x94, query:** takes no parameter and returns the pending event code.

The host polls a status byte at the command port to pace its transfers. Bit 0 of that byte is output-buffer-full and bit 1 is input-buffer-full. Inside, the sequencer drives a read/write interface into a small byte-wide register file stub, and a one-byte pending-event holder feeds the query.

The sequencer has four named states:

- `S_IDLE`: no command is open.
- `S_RD_ADDR`: a read waits for its address byte.
- `S_WR_ADDR`: a write waits for its address byte.
- `S_WR_DATA`: a write waits for its data byte.

A consumed command byte moves the sequencer as follows:

- 0x90 goes to `S_RD_ADDR`.
- 0x91 goes to `S_WR_ADDR`.
- 0x94 or any other value goes to `S_IDLE`.

A consumed data byte moves it as follows:

- `S_RD_ADDR` goes to `S_IDLE` and loads the result.
- `S_WR_ADDR` goes to `S_WR_DATA` and latches the address.
- `S_WR_DATA` goes to `S_IDLE` and writes the register.
- `S_IDLE` stays in `S_IDLE` and discards the byte.

Each host write is held in an input buffer for one clock. The sequencer consumes it on the next edge.

Top module: `hostcmd_decoder`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00, the pending event code is 0x00 and every register-file byte is 0x00.
- R2: A read of the command port (0x66) returns the status byte: bit 0 is output-buffer-full, bit 1 is input-buffer-full, and bits 7..2 are 0.
- R3: A host write to either port sets input-buffer-full at that clock edge. The flag clears at the next edge, when the byte is consumed, unless another write arrives in that cycle.
- R4: Command 0x90 followed by an address byte loads the register byte at that address into the output buffer and sets output-buffer-full at the edge that consumes the address byte.
- R5: Command 0x91 followed by an address byte and a data byte stores the data byte at that address and leaves output-buffer-full unchanged.
- R6: Command 0x94 loads the pending event code into the output buffer, sets output-buffer-full and clears the pending code to 0x00. With no event pending it returns 0x00.
- R7: A host read of the data port (0x62) returns the output buffer and clears output-buffer-full.
- R8: A command byte written while a read or write sequence is open abandons that sequence, with no register write, and starts decoding the new opcode.
- R9: A command byte other than 0x90, 0x91 or 0x94 returns the sequencer to idle with no result byte.
- R10: A data byte received while idle is discarded: no register write and no result byte.
- R11: Register addresses at or above DEPTH (default 32) read as 0x00, and writes to them are dropped without aliasing onto lower addresses.
- R12: An event pulse loads its code as the pending event, replacing any older code. A pulse in the same cycle as a query's clear is kept, and the query returns the older code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read mux: status at 0x66, output buffer at 0x62, else 0 |
| evt_valid | input | 1 | Event pulse |
| evt_code | input | 8 | Event code, taken when evt_valid is high |

## Verification
The bench aims at the points where a sequencer tends to lose track of its place:

- **Abort.** A command byte arriving mid-sequence is tested for abort. A design that kept its old state would store a stray byte or return a stale result.
- **Discarded bytes.** Unknown opcodes, and data bytes sent while idle, are followed by read-backs. A decoder that treated them as parameters would show a changed register or a raised output-buffer-full.
- **Out-of-range addresses.** Addresses at and above the register-file depth are written and then the low addresses are re-read. A design that truncated addresses would alias onto those lower bytes.
- **Event pulse during a query clear.** An event pulse is driven in the very cycle a query clears the pending code. A design that let the clear win would lose the new event.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
    localparam logic [7:0] OP_READ  = 8'h90;
    localparam logic [7:0] OP_WRITE = 8'h91;
    localparam logic [7:0] OP_QUERY = 8'h94;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RD_ADDR = 2'd1,
        S_WR_ADDR = 2'd2,
        S_WR_DATA = 2'd3
    } seq_state_t;
endpackage

// File: rtl/hcd_regfile.sv
module hcd_regfile #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (32'(addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && in_range) begin
            mem[addr[AW-1:0]] <= wdata;
        end
    end

    assign rdata = in_range ? mem[addr[AW-1:0]] : '0;
endmodule

// File: rtl/hcd_event.sv
module hcd_event #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [DW-1:0] code,
    input  logic          clr,
    output logic [DW-1:0] pending
);
    always_ff @(posedge clk) begin
        if (!rst_n)   pending <= '0;
        else if (set) pending <= code;
        else if (clr) pending <= '0;
    end

    // R6: a clear without a new pulse empties the holder
    p_evt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> (pending == '0));

    // R12: a pulse always lands, even against a clear
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (pending == $past(code)));
endmodule

// File: rtl/hcd_seq.sv
module hcd_seq
    import hcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_is_cmd,
    input  logic [7:0] wr_byte,
    input  logic       rd_data_stb,
    input  logic [7:0] evt_pending,
    output logic       evt_clr,
    output logic       rf_we,
    output logic [7:0] rf_addr,
    output logic [7:0] rf_wdata,
    input  logic [7:0] rf_rdata,
    output logic       ibf,
    output logic       obf,
    output logic [7:0] obuf
);
    seq_state_t st, nxt;
    logic [7:0] ibuf;
    logic       ibuf_cmd;
    logic [7:0] addr_q;
    logic       load;
    logic [7:0] load_val;
    logic       addr_load;
    logic       consume_cmd, consume_data;

    assign consume_cmd  = ibf && ibuf_cmd;
    assign consume_data = ibf && !ibuf_cmd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = st;
        load      = 1'b0;
        load_val  = 8'h00;
        evt_clr   = 1'b0;
        rf_we     = 1'b0;
        addr_load = 1'b0;
        rf_addr   = (st == S_WR_DATA) ? addr_q : ibuf;
        rf_wdata  = ibuf;
        if (consume_cmd) begin
            unique case (ibuf)
                OP_READ:  nxt = S_RD_ADDR;
                OP_WRITE: nxt = S_WR_ADDR;
                OP_QUERY: begin
                    nxt      = S_IDLE;
                    load     = 1'b1;
                    load_val = evt_pending;
                    evt_clr  = 1'b1;
                end
                default:  nxt = S_IDLE;
            endcase
        end else if (consume_data) begin
            unique case (st)
                S_IDLE:    nxt = S_IDLE;
                S_RD_ADDR: begin
                    nxt      = S_IDLE;
                    load     = 1'b1;
                    load_val = rf_rdata;
                end
                S_WR_ADDR: begin
                    nxt       = S_WR_DATA;
                    addr_load = 1'b1;
                end
                S_WR_DATA: begin
                    nxt   = S_IDLE;
                    rf_we = 1'b1;
                end
            endcase
        end
    end

    // host-facing buffers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf      <= 1'b0;
            ibuf     <= 8'h00;
            ibuf_cmd <= 1'b0;
            obf      <= 1'b0;
            obuf     <= 8'h00;
            addr_q   <= 8'h00;
        end else begin
            if (wr_stb) begin
                ibf      <= 1'b1;
                ibuf     <= wr_byte;
                ibuf_cmd <= wr_is_cmd;
            end else if (ibf) begin
                ibf <= 1'b0;
            end
            if (addr_load) addr_q <= ibuf;
            if (load) begin
                obf  <= 1'b1;
                obuf <= load_val;
            end else if (rd_data_stb) begin
                obf <= 1'b0;
            end
        end
    end

    // R3: the input buffer empties one edge after a lone write
    p_ibf_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !wr_stb) |=> !ibf);

    // R7: a host data read with no new result clears output-buffer-full
    p_obf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_stb && !load) |=> !obf);

    // R4: an address byte in a read raises output-buffer-full
    p_read_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_data && st == S_RD_ADDR) |=> obf);

    // R5: the final write byte never produces a result
    p_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_data && st == S_WR_DATA && !rd_data_stb) |=> $stable(obf));

    // R8: a write opcode restarts decoding from any state
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_cmd && ibuf == OP_WRITE) |=> (st == S_WR_ADDR));

    // R9: unknown opcodes land in idle
    p_unknown_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_cmd && ibuf != OP_READ && ibuf != OP_WRITE && ibuf != OP_QUERY)
        |=> (st == S_IDLE));

    // R10: data while idle yields no write
    p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_data && st == S_IDLE) |-> !rf_we);
endmodule

// File: rtl/hostcmd_decoder.sv
module hostcmd_decoder #(
    parameter int          AW_HOST   = 16,
    parameter int          DEPTH     = 32,
    parameter logic [15:0] CMD_PORT  = 16'h0066,
    parameter logic [15:0] DATA_PORT = 16'h0062
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [AW_HOST-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               evt_valid,
    input  logic [7:0]         evt_code
);
    logic       at_cmd, at_data;
    logic       wr_stb, rd_data_stb;
    logic       evt_clr;
    logic [7:0] evt_pending;
    logic       rf_we;
    logic [7:0] rf_addr, rf_wdata, rf_rdata;
    logic       ibf, obf;
    logic [7:0] obuf;

    assign at_cmd      = (host_addr == AW_HOST'(CMD_PORT));
    assign at_data     = (host_addr == AW_HOST'(DATA_PORT));
    assign wr_stb      = host_wr && (at_cmd || at_data);
    assign rd_data_stb = host_rd && at_data;

    hcd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_is_cmd   (at_cmd),
        .wr_byte     (host_wdata),
        .rd_data_stb (rd_data_stb),
        .evt_pending (evt_pending),
        .evt_clr     (evt_clr),
        .rf_we       (rf_we),
        .rf_addr     (rf_addr),
        .rf_wdata    (rf_wdata),
        .rf_rdata    (rf_rdata),
        .ibf         (ibf),
        .obf         (obf),
        .obuf        (obuf)
    );

    hcd_regfile #(.DEPTH(DEPTH), .DW(8)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (rf_addr),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    hcd_event #(.DW(8)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (evt_valid),
        .code    (evt_code),
        .clr     (evt_clr),
        .pending (evt_pending)
    );

    always_comb begin
        if (at_cmd)       host_rdata = {6'b0, ibf, obf};
        else if (at_data) host_rdata = obuf;
        else              host_rdata = 8'h00;
    end
endmodule

// File: tb/hostcmd_decoder_test.sv
`timescale 1ns/1ps
module hostcmd_decoder_test;
    localparam logic [15:0] CP = 16'h0066;
    localparam logic [15:0] DP = 16'h0062;
    localparam int DEPTH = 32;
    localparam int NV = 8;
    localparam logic [7:0] VA [NV] = '{8'd0, 8'd1, 8'd31, 8'd16, 8'd7, 8'd32, 8'd200, 8'd255};
    localparam logic [7:0] VD [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h00, 8'h77, 8'h5A, 8'hEE};

    logic clk = 0, rst_n = 0, host_wr = 0, host_rd = 0, evt_valid = 0;
    logic [15:0] host_addr = '0;
    logic [7:0] host_wdata = '0, evt_code = '0, host_rdata;
    int n_chk = 0, n_bad = 0;
    logic [7:0] v;

    always #2 clk = ~clk;

    hostcmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_valid(evt_valid), .evt_code(evt_code)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    // one write strobe, then one idle cycle so the byte is consumed
    task automatic hw(input logic [15:0] port, input logic [7:0] b);
        host_wr = 1; host_addr = port; host_wdata = b;
        tick();
        host_wr = 0;
        tick();
    endtask

    task automatic hr(input logic [15:0] port, output logic [7:0] b);
        host_rd = 1; host_addr = port;
        #0.5 b = host_rdata;
        tick();
        host_rd = 0;
    endtask

    task automatic peek(input logic [15:0] port, output logic [7:0] b);
        host_addr = port;
        #0.5 b = host_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        hw(CP, 8'h91); hw(DP, a); hw(DP, d);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        hw(CP, 8'h90); hw(DP, a); hr(DP, d);
    endtask

    task automatic query(output logic [7:0] d);
        hw(CP, 8'h94); hr(DP, d);
    endtask

    task automatic pulse(input logic [7:0] c);
        evt_valid = 1; evt_code = c; tick(); evt_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        peek(CP, v); check("R1 status", v, 8'h00);
        peek(DP, v); check("R1 data", v, 8'h00);
        rd_reg(8'd5, v); check("R1 reg5", v, 8'h00);
        query(v); check("R1 event", v, 8'h00);

        // R3 / R2 input-buffer-full timing
        host_wr = 1; host_addr = CP; host_wdata = 8'h90;
        tick();
        host_wr = 0;
        peek(CP, v); check("R3 ibf set", v, 8'h02);
        tick();
        peek(CP, v); check("R3 ibf clear", v, 8'h00);
        hw(DP, 8'd3);
        peek(CP, v); check("R2 obf bit0", v, 8'h01);
        hr(DP, v); check("R4 read reg3", v, 8'h00);
        peek(CP, v); check("R7 obf cleared", v, 8'h00);

        // table: write then read back
        for (int i = 0; i < NV; i++) begin
            wr_reg(VA[i], VD[i]);
            peek(CP, v); check("R5 no result", v, 8'h00);
            rd_reg(VA[i], v);
            check(32'(VA[i]) < DEPTH ? "R4 readback" : "R11 oob reads 0",
                  v, 32'(VA[i]) < DEPTH ? VD[i] : 8'h00);
        end
        rd_reg(8'd0, v);  check("R11 no alias 0", v, 8'hA5);
        rd_reg(8'd31, v); check("R11 no alias 31", v, 8'hFF);
        rd_reg(8'd8, v);  check("R11 no alias 8", v, 8'h00);

        // R6 query
        pulse(8'h42);
        query(v); check("R6 query code", v, 8'h42);
        query(v); check("R6 cleared", v, 8'h00);
        // R12 overwrite
        pulse(8'h11); pulse(8'h22);
        query(v); check("R12 newest", v, 8'h22);
        // R12 pulse in the clearing cycle
        pulse(8'h33);
        host_wr = 1; host_addr = CP; host_wdata = 8'h94;
        tick();
        host_wr = 0; evt_valid = 1; evt_code = 8'h77;
        tick();
        evt_valid = 0;
        hr(DP, v); check("R12 old code", v, 8'h33);
        query(v); check("R12 pulse kept", v, 8'h77);

        // R8 abort write by read
        hw(CP, 8'h91); hw(DP, 8'd2);
        hw(CP, 8'h90); hw(DP, 8'd2);
        hr(DP, v); check("R8 write aborted", v, 8'h00);
        // R8 abort read by write
        hw(CP, 8'h90);
        wr_reg(8'd3, 8'h44);
        peek(CP, v); check("R8 no read result", v, 8'h00);
        rd_reg(8'd3, v); check("R8 new write", v, 8'h44);

        // R9 unknown opcode
        hw(CP, 8'hAB); hw(DP, 8'd4); hw(DP, 8'h99);
        peek(CP, v); check("R9 no result", v, 8'h00);
        rd_reg(8'd4, v); check("R9 no write", v, 8'h00);
        // R10 data while idle
        hw(DP, 8'd6); hw(DP, 8'h5E);
        peek(CP, v); check("R10 no result", v, 8'h00);
        rd_reg(8'd6, v); check("R10 no write", v, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule